// File: doc/BRIEF.md
# Execute-Stage Redirect Generator

This block sits at the end of the execute stage of an out-of-order core. Each cycle it sees the group of instructions finishing execution, one slot per instruction. Each slot carries a valid bit, a squashed bit, a mispredict bit, the predicted-taken bit, a sequence number, the instruction address and the resolved next address. A single input reports that the load/store queue has found a memory-ordering violation. From this it forms at most one front-end redirect for the group and registers it for one cycle.

The slots are scanned from the oldest (index 0) upward. A slot that is valid and not squashed is called live. When the violation input is high, the first live slot produces the redirect. If that slot's branch was mispredicted, the redirect is a branch redirect; otherwise it is a memory-order redirect. When the violation input is low, the first live mispredicted slot produces a branch redirect. Every later slot in the group is ignored. Two free-running counters record the redirects of interest. One counts branch redirects whose branch had been predicted taken. The other counts memory-order redirects. Flushing the rest of the pipeline is left to the stages that consume the record.

Top module: `redirect_gen`

## Requirements
- R1: While reset is high, and on the first clock edge with reset high, every output is cleared to zero, including both counters.
- R2: At most one redirect is issued per group. Among the slots that qualify, the lowest index (the oldest) wins. Slot i occupies bits [i*W +: W] of each packed slot field.
- R3: A branch redirect sets redirect valid and the branch flag. It carries the winning slot's sequence number, its address on the mispredicted-PC output and its next address on the target output.
- R4: On a branch redirect the corrected-taken bit is 1 exactly when the next address differs from the address plus the 4-byte instruction size.
- R5: A memory-order redirect sets redirect valid and carries the winning slot's sequence number and next address. The branch flag, the mispredicted-PC output and the corrected-taken bit are all zero.
- R6: A slot that is invalid or squashed never produces a redirect, even if it is mispredicted. If the violation input is high but no slot is live, there is no redirect.
- R7: Within the winning slot, the mispredict bit is tested before the violation. When the violation input is high, the first live slot redirects, as a branch if it is mispredicted and as a memory-order redirect otherwise.
- R8: The taken-wrong counter goes up by one for each branch redirect whose winning slot had predicted-taken set. Predicted-taken on any non-winning slot has no effect.
- R9: The memory-order counter goes up by one for each memory-order redirect and for no other event.
- R10: The record is registered. It shows on the outputs after the clock edge that samples the group and lasts exactly one cycle. Every record field is zero whenever redirect valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_valid | input | SLOTS | Slot holds a completing instruction |
| slot_squashed | input | SLOTS | Slot's instruction was already squashed |
| slot_mispred | input | SLOTS | Slot's branch resolved against its prediction |
| slot_pred_taken | input | SLOTS | Slot's branch had been predicted taken |
| slot_seq | input | SLOTS*SEQ_W | Packed sequence numbers |
| slot_pc | input | SLOTS*PC_W | Packed instruction addresses |
| slot_npc | input | SLOTS*PC_W | Packed resolved next addresses |
| mem_order_viol | input | 1 | Load/store queue reports an ordering violation |
| rd_valid | output | 1 | Redirect record valid (squash) |
| rd_seq | output | SEQ_W | Sequence number of the redirecting instruction |
| rd_target | output | PC_W | Next fetch address |
| rd_branch | output | 1 | Record is a branch mispredict |
| rd_mis_pc | output | PC_W | Address of the mispredicted branch |
| rd_taken | output | 1 | Corrected taken direction |
| cnt_taken_wrong | output | CNT_W | Count of redirects from predicted-taken branches |
| cnt_mem_order | output | CNT_W | Count of memory-order redirects |

## Verification
The groups tried are: a single mispredict in a middle slot, two mispredicts, mispredicts hidden behind squashed or invalid older slots, and a clean group with no trigger. These separate true oldest-first priority from a last-wins or a live-blind scan. Violation groups are tried with a clean first slot, a mispredicted first slot, a squashed first slot and no live slot at all. Together these show whether the mispredict test comes first and whether the violation attaches to the right slot. Pairs of targets that equal and that differ from the sequential address exercise the taken bit. Predicted-taken bits on losing slots confirm that only the winner moves the counters.

// File: rtl/rdr_pkg.sv
package rdr_pkg;

    typedef enum logic [1:0] {
        EV_NONE   = 2'd0,
        EV_BRANCH = 2'd1,
        EV_MEMORD = 2'd2
    } rdr_kind_e;

    typedef struct packed {
        logic trig;      // slot qualifies for a redirect
        logic is_br;     // slot branch mispredicted
        logic pred_tk;   // slot predicted taken
        logic corr_tk;   // corrected direction
    } slot_flags_t;

    function automatic rdr_kind_e classify(input logic any, input logic is_br);
        if (!any)
            return EV_NONE;
        else if (is_br)
            return EV_BRANCH;
        else
            return EV_MEMORD;
    endfunction

endpackage

// File: rtl/rdr_slot_eval.sv
module rdr_slot_eval
    import rdr_pkg::*;
#(
    parameter int PC_W       = 32,
    parameter int INST_BYTES = 4
) (
    input  logic             valid,
    input  logic             squashed,
    input  logic             mispred,
    input  logic             pred_taken,
    input  logic             mem_viol,
    input  logic [PC_W-1:0]  pc,
    input  logic [PC_W-1:0]  npc,
    output slot_flags_t      flags
);
    logic live;
    logic [PC_W-1:0] seq_pc;

    assign live   = valid & ~squashed;
    assign seq_pc = pc + PC_W'(INST_BYTES);

    always_comb begin
        flags.trig    = live & (mispred | mem_viol);
        flags.is_br   = mispred;
        flags.pred_tk = pred_taken;
        flags.corr_tk = (npc != seq_pc);
    end
endmodule

// File: rtl/rdr_oldest_pick.sv
module rdr_oldest_pick #(
    parameter int SLOTS = 4,
    localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SLOTS-1:0] trig,
    output logic [SLOTS-1:0] grant,
    output logic [IDX_W-1:0] idx,
    output logic             any
);
    always_comb begin
        grant = '0;
        idx   = '0;
        any   = 1'b0;
        for (int i = 0; i < SLOTS; i++) begin
            if (trig[i] && !any) begin
                grant[i] = 1'b1;
                idx      = IDX_W'(i);
                any      = 1'b1;
            end
        end
    end

    // R2
    one_winner_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    // R2
    grant_from_trig_chk: assert property (@(posedge clk) disable iff (rst)
        (grant & ~trig) == '0);
endmodule

// File: rtl/rdr_record_reg.sv
module rdr_record_reg
    import rdr_pkg::*;
#(
    parameter int SEQ_W = 16,
    parameter int PC_W  = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  rdr_kind_e        kind,
    input  logic [SEQ_W-1:0] seq,
    input  logic [PC_W-1:0]  pc,
    input  logic [PC_W-1:0]  npc,
    input  logic             corr_tk,
    output logic             rd_valid,
    output logic [SEQ_W-1:0] rd_seq,
    output logic [PC_W-1:0]  rd_target,
    output logic             rd_branch,
    output logic [PC_W-1:0]  rd_mis_pc,
    output logic             rd_taken
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid  <= 1'b0;
            rd_seq    <= '0;
            rd_target <= '0;
            rd_branch <= 1'b0;
            rd_mis_pc <= '0;
            rd_taken  <= 1'b0;
        end else begin
            rd_valid  <= (kind != EV_NONE);
            rd_seq    <= (kind != EV_NONE) ? seq : '0;
            rd_target <= (kind != EV_NONE) ? npc : '0;
            rd_branch <= (kind == EV_BRANCH);
            rd_mis_pc <= (kind == EV_BRANCH) ? pc : '0;
            rd_taken  <= (kind == EV_BRANCH) ? corr_tk : 1'b0;
        end
    end

    // R3
    branch_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
        rd_branch |-> rd_valid);
endmodule

// File: rtl/rdr_event_ctr.sv
module rdr_event_ctr
    import rdr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  rdr_kind_e        kind,
    input  logic             pred_tk,
    output logic [CNT_W-1:0] cnt_taken_wrong,
    output logic [CNT_W-1:0] cnt_mem_order
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_taken_wrong <= '0;
            cnt_mem_order   <= '0;
        end else begin
            if (kind == EV_BRANCH && pred_tk)
                cnt_taken_wrong <= cnt_taken_wrong + CNT_W'(1);
            if (kind == EV_MEMORD)
                cnt_mem_order <= cnt_mem_order + CNT_W'(1);
        end
    end
endmodule

// File: rtl/redirect_gen.sv
module redirect_gen
    import rdr_pkg::*;
#(
    parameter int SLOTS      = 4,
    parameter int SEQ_W      = 16,
    parameter int PC_W       = 32,
    parameter int CNT_W      = 16,
    parameter int INST_BYTES = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [SLOTS-1:0]       slot_valid,
    input  logic [SLOTS-1:0]       slot_squashed,
    input  logic [SLOTS-1:0]       slot_mispred,
    input  logic [SLOTS-1:0]       slot_pred_taken,
    input  logic [SLOTS*SEQ_W-1:0] slot_seq,
    input  logic [SLOTS*PC_W-1:0]  slot_pc,
    input  logic [SLOTS*PC_W-1:0]  slot_npc,
    input  logic                   mem_order_viol,
    output logic                   rd_valid,
    output logic [SEQ_W-1:0]       rd_seq,
    output logic [PC_W-1:0]        rd_target,
    output logic                   rd_branch,
    output logic [PC_W-1:0]        rd_mis_pc,
    output logic                   rd_taken,
    output logic [CNT_W-1:0]       cnt_taken_wrong,
    output logic [CNT_W-1:0]       cnt_mem_order
);
    localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;

    slot_flags_t      flags [SLOTS];
    logic [SEQ_W-1:0] seq_a [SLOTS];
    logic [PC_W-1:0]  pc_a  [SLOTS];
    logic [PC_W-1:0]  npc_a [SLOTS];
    logic [SLOTS-1:0] trig_v;
    logic [SLOTS-1:0] grant;
    logic [IDX_W-1:0] sel_idx;
    logic             any_trig;

    genvar g;
    generate
        for (g = 0; g < SLOTS; g++) begin : g_slot
            assign seq_a[g] = slot_seq[g*SEQ_W +: SEQ_W];
            assign pc_a[g]  = slot_pc[g*PC_W +: PC_W];
            assign npc_a[g] = slot_npc[g*PC_W +: PC_W];

            rdr_slot_eval #(
                .PC_W       (PC_W),
                .INST_BYTES (INST_BYTES)
            ) u_eval (
                .valid      (slot_valid[g]),
                .squashed   (slot_squashed[g]),
                .mispred    (slot_mispred[g]),
                .pred_taken (slot_pred_taken[g]),
                .mem_viol   (mem_order_viol),
                .pc         (pc_a[g]),
                .npc        (npc_a[g]),
                .flags      (flags[g])
            );
            assign trig_v[g] = flags[g].trig;
        end
    endgenerate

    rdr_oldest_pick #(.SLOTS(SLOTS)) u_pick (
        .clk   (clk),
        .rst   (rst),
        .trig  (trig_v),
        .grant (grant),
        .idx   (sel_idx),
        .any   (any_trig)
    );

    slot_flags_t      sel_flags;
    logic [SEQ_W-1:0] sel_seq;
    logic [PC_W-1:0]  sel_pc;
    logic [PC_W-1:0]  sel_npc;
    rdr_kind_e        kind;

    always_comb begin
        sel_flags = flags[sel_idx];
        sel_seq   = seq_a[sel_idx];
        sel_pc    = pc_a[sel_idx];
        sel_npc   = npc_a[sel_idx];
        kind      = classify(any_trig, sel_flags.is_br);
    end

    rdr_record_reg #(.SEQ_W(SEQ_W), .PC_W(PC_W)) u_rec (
        .clk       (clk),
        .rst       (rst),
        .kind      (kind),
        .seq       (sel_seq),
        .pc        (sel_pc),
        .npc       (sel_npc),
        .corr_tk   (sel_flags.corr_tk),
        .rd_valid  (rd_valid),
        .rd_seq    (rd_seq),
        .rd_target (rd_target),
        .rd_branch (rd_branch),
        .rd_mis_pc (rd_mis_pc),
        .rd_taken  (rd_taken)
    );

    rdr_event_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk             (clk),
        .rst             (rst),
        .kind            (kind),
        .pred_tk         (sel_flags.pred_tk),
        .cnt_taken_wrong (cnt_taken_wrong),
        .cnt_mem_order   (cnt_mem_order)
    );

    // R10
    one_cycle_rec_chk: assert property (@(posedge clk) disable iff (rst)
        !any_trig |=> !rd_valid);

    // R10
    idle_fields_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_valid |-> (rd_seq == '0 && rd_target == '0 && rd_mis_pc == '0 && !rd_taken));

    // R4
    taken_dir_chk: assert property (@(posedge clk) disable iff (rst)
        rd_branch |-> (rd_taken == (rd_target != (rd_mis_pc + PC_W'(INST_BYTES)))));

    // R9
    mem_ctr_pairs_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_mem_order != $past(cnt_mem_order)) |-> (rd_valid && !rd_branch));

    // R8
    tk_ctr_pairs_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_taken_wrong != $past(cnt_taken_wrong)) |-> rd_branch);
endmodule

// File: tb/tb_redirect_gen.sv
module tb_redirect_gen;
    localparam int SLOTS = 4;
    localparam int SEQ_W = 16;
    localparam int PC_W  = 32;
    localparam int CNT_W = 16;

    logic                   clk = 1'b0;
    logic                   rst = 1'b1;
    logic [SLOTS-1:0]       s_valid, s_sq, s_mp, s_pt;
    logic [SLOTS*SEQ_W-1:0] s_seq;
    logic [SLOTS*PC_W-1:0]  s_pc, s_npc;
    logic                   viol;
    logic                   rd_valid, rd_branch, rd_taken;
    logic [SEQ_W-1:0]       rd_seq;
    logic [PC_W-1:0]        rd_target, rd_mis_pc;
    logic [CNT_W-1:0]       c_tk, c_mem;

    int n_chk = 0;
    int n_fail = 0;
    int exp_tk = 0;
    int exp_mem = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    redirect_gen #(.SLOTS(SLOTS), .SEQ_W(SEQ_W), .PC_W(PC_W), .CNT_W(CNT_W)) dut (
        .clk(clk), .rst(rst),
        .slot_valid(s_valid), .slot_squashed(s_sq), .slot_mispred(s_mp),
        .slot_pred_taken(s_pt), .slot_seq(s_seq), .slot_pc(s_pc), .slot_npc(s_npc),
        .mem_order_viol(viol),
        .rd_valid(rd_valid), .rd_seq(rd_seq), .rd_target(rd_target),
        .rd_branch(rd_branch), .rd_mis_pc(rd_mis_pc), .rd_taken(rd_taken),
        .cnt_taken_wrong(c_tk), .cnt_mem_order(c_mem)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_in();
        s_valid = '0; s_sq = '0; s_mp = '0; s_pt = '0;
        s_seq = '0; s_pc = '0; s_npc = '0; viol = 1'b0;
    endtask

    // all slots live, sequential next address, no mispredict
    task automatic fill(input int seq0, input int pc0);
        clear_in();
        for (int i = 0; i < SLOTS; i++) begin
            s_valid[i] = 1'b1;
            s_seq[i*SEQ_W +: SEQ_W] = SEQ_W'(seq0 + i);
            s_pc[i*PC_W +: PC_W]    = PC_W'(pc0 + 4*i);
            s_npc[i*PC_W +: PC_W]   = PC_W'(pc0 + 4*i + 4);
        end
    endtask

    task automatic set_br(input int i, input logic pt, input int npc);
        s_mp[i] = 1'b1;
        s_pt[i] = pt;
        s_npc[i*PC_W +: PC_W] = PC_W'(npc);
    endtask

    task automatic expect_rec(input string req, input logic v, input int seq,
                              input int tgt, input logic br, input int mpc, input logic tk);
        chk({req, " valid"},  64'(rd_valid),  64'(v));
        chk({req, " seq"},    64'(rd_seq),    64'(seq));
        chk({req, " target"}, 64'(rd_target), 64'(tgt));
        chk({req, " branch"}, 64'(rd_branch), 64'(br));
        chk({req, " mispc"},  64'(rd_mis_pc), 64'(mpc));
        chk({req, " taken"},  64'(rd_taken),  64'(tk));
    endtask

    task automatic expect_ctr(input string req);
        chk({req, " tk_ctr"},  64'(c_tk),  64'(exp_tk));
        chk({req, " mem_ctr"}, 64'(c_mem), 64'(exp_mem));
    endtask

    // present at negedge, sample after the capturing edge, then idle
    task automatic run_group();
        @(posedge clk); #1;
    endtask

    task automatic idle_check(input string req);
        clear_in();
        @(posedge clk); #1;
        expect_rec({req, " idle after"}, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic t_reset();
        clear_in();
        s_valid = '1; s_mp = '1; viol = 1'b1;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        expect_rec("R1 reset", 0, 0, 0, 0, 0, 0);
        expect_ctr("R1 reset");
        @(negedge clk);
        clear_in();
        rst = 1'b0;
    endtask

    task automatic t_single_branch();
        @(negedge clk);
        fill(10, 32'h1000);
        set_br(2, 1'b0, 32'h2000);
        #1;
        chk("R10 not before edge", 64'(rd_valid), 64'd0);
        run_group();
        // R3 R4: slot 2 target differs from pc+4 -> taken
        expect_rec("R3", 1, 12, 32'h2000, 1, 32'h1008, 1);
        expect_ctr("R8 no pt");
        idle_check("R10");
    endtask

    task automatic t_two_branches();
        @(negedge clk);
        fill(20, 32'h1100);
        set_br(1, 1'b1, 32'h1108);   // equals pc+4 -> not taken
        set_br(3, 1'b1, 32'h7000);
        run_group();
        exp_tk++;
        expect_rec("R2 oldest R4 not-taken", 1, 21, 32'h1108, 1, 32'h1104, 0);
        expect_ctr("R8 single count");
        idle_check("R2");
    endtask

    task automatic t_squashed_skip();
        @(negedge clk);
        fill(30, 32'h1200);
        set_br(0, 1'b1, 32'h9000); s_sq[0] = 1'b1;
        set_br(1, 1'b1, 32'h9100); s_valid[1] = 1'b0;
        set_br(2, 1'b0, 32'h3000);
        run_group();
        expect_rec("R6 skip dead", 1, 32, 32'h3000, 1, 32'h1208, 1);
        expect_ctr("R8 dead pt");
        idle_check("R6");
    endtask

    task automatic t_mem_clean();
        @(negedge clk);
        fill(40, 32'h1300);
        s_pt[0] = 1'b1;
        viol = 1'b1;
        run_group();
        exp_mem++;
        expect_rec("R5 mem", 1, 40, 32'h1304, 0, 0, 0);
        expect_ctr("R9 mem");
        idle_check("R5");
    endtask

    task automatic t_mem_vs_branch();
        @(negedge clk);
        fill(50, 32'h1400);
        set_br(0, 1'b1, 32'h5000);
        viol = 1'b1;
        run_group();
        exp_tk++;
        expect_rec("R7 branch first", 1, 50, 32'h5000, 1, 32'h1400, 1);
        expect_ctr("R7 ctr");
        idle_check("R7");
    endtask

    task automatic t_mem_after_squash();
        @(negedge clk);
        fill(60, 32'h1500);
        s_sq[0] = 1'b1;
        set_br(2, 1'b1, 32'h6000);
        viol = 1'b1;
        run_group();
        exp_mem++;
        expect_rec("R7 first live slot", 1, 61, 32'h1508, 0, 0, 0);
        expect_ctr("R9 R8 squash");
        idle_check("R7 b");
    endtask

    task automatic t_no_trigger();
        @(negedge clk);
        fill(70, 32'h1600);
        s_pt = '1;
        set_br(3, 1'b1, 32'h8000); s_valid[3] = 1'b0;
        run_group();
        expect_rec("R6 none", 0, 0, 0, 0, 0, 0);
        @(negedge clk);
        clear_in();
        s_valid = 4'b0011; s_sq = 4'b0011; s_mp = '1; viol = 1'b1;
        run_group();
        expect_rec("R6 viol no live", 0, 0, 0, 0, 0, 0);
        expect_ctr("R6 ctr");
        clear_in();
    endtask

    task automatic t_back_to_back();
        @(negedge clk);
        fill(80, 32'h1700);
        viol = 1'b1;
        run_group();
        exp_mem++;
        expect_rec("R10 b2b first", 1, 80, 32'h1704, 0, 0, 0);
        fill(90, 32'h1800);
        set_br(1, 1'b1, 32'h1808);
        run_group();
        exp_tk++;
        expect_rec("R10 b2b second", 1, 91, 32'h1808, 1, 32'h1804, 0);
        expect_ctr("R9 R8 b2b");
        idle_check("R10 b2b");
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_single_branch();
        t_two_branches();
        t_squashed_skip();
        t_mem_clean();
        t_mem_vs_branch();
        t_mem_after_squash();
        t_no_trigger();
        t_back_to_back();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule